// File: doc/BRIEF.md
# SRAM Bank Enable Controller

This block decides which banks of a banked on-chip SRAM are powered and reachable. Software writes a bank-enable word over a simple register write port. The block normalises every written word so that the enabled banks always form one unbroken run that starts at bank 0. The lowest bank can never be switched off. A set bit above a cleared one fills every bank beneath it.

Memory traffic reaches the array through a valid/ready access port. The bank is taken from the upper address bits. A read of a switched-off bank returns zero, and a write to one is dropped. A switched-off bank keeps its old contents, so they reappear when the bank is turned back on.

Whenever a write actually changes the enable set, the configuration-ready flag goes low for a fixed settle time. During that time the access port holds off requests. Requests are not lost: each one completes as soon as the flag returns high.

Top module: `sram_bank_ctrl`

## Requirements
- R1: After reset the stored enable word is all ones, cfg_ready is 1 and mem_ready is 1.
- R2: Bit 0 of the stored enable word is always 1; writing all zeros stores 00000001.
- R3: A written word is stored with bit i set when any written bit at position i or above is set; writing 00010111 stores 00011111, so the stored word is always of the form 0..01..1.
- R4: A register write whose normalised value differs from the stored word clears cfg_ready on the following clock. cfg_ready stays 0 for exactly SETTLE_CYCLES cycles, then returns to 1.
- R5: A register write whose normalised value equals the stored word leaves cfg_ready unchanged and starts no settle period.
- R6: While cfg_ready is 0, mem_ready is 0 and a held request is not accepted. The request completes with correct data once cfg_ready is 1 again.
- R7: The bank index is mem_addr divided by WORDS_PER_BANK. An accepted read of a bank whose enable bit is 0 returns all zeros.
- R8: An accepted write to a bank whose enable bit is 0 is discarded. The word keeps its earlier value, and that value is read back after the bank is enabled again.
- R9: An accepted read raises mem_rvalid for one cycle on the next clock, with mem_rdata holding the word last written to that address in an enabled bank.
- R10: A changing register write made during a settle period restarts the count, so cfg_ready stays 0 for SETTLE_CYCLES cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Enable-word write strobe |
| cfg_wdata | input | NUM_BANKS | Requested bank-enable word |
| cfg_en | output | NUM_BANKS | Stored, normalised enable word |
| cfg_ready | output | 1 | High when the enable set is in effect |
| mem_valid | input | 1 | Access request |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | $clog2(NUM_BANKS*WORDS_PER_BANK) | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_ready | output | 1 | Access accepted when high with mem_valid |
| mem_rvalid | output | 1 | Read data valid |
| mem_rdata | output | DATA_W | Read data |

## Verification
The bench writes non-contiguous enable words with holes and a cleared bit 0. A normaliser that only copies the word, or only fixes bit 0, would store an illegal pattern. It times the ready-low window exactly, both for a single change and for a change made mid-settle. A counter off by one, or one that failed to restart, would shorten or stretch the window. It parks reads and writes on the port during a settle period and writes into a switched-off bank. A design that dropped stalled requests, or let a write through to a disabled bank, would show the wrong word after the bank is turned back on.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [0:0] {
      SETTLE_IDLE = 1'b0,
      SETTLE_RUN  = 1'b1
   } settle_state_e;
endpackage

// File: rtl/sbc_normalize.sv
module sbc_normalize #(
   parameter int NUM_BANKS = 8
) (
   input  logic [NUM_BANKS-1:0] raw_i,
   output logic [NUM_BANKS-1:0] norm_o
);
   // Lowest bank is hard-wired on.
   assign norm_o[0] = 1'b1;

   // Each higher bit is set when it or anything above it is requested.
   for (genvar i = 1; i < NUM_BANKS; i++) begin : g_fill
      assign norm_o[i] = |raw_i[NUM_BANKS-1:i];
   end
endmodule

// File: rtl/sbc_settle_timer.sv
module sbc_settle_timer
   import sbc_pkg::*;
#(
   parameter int SETTLE_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic ready_o
);
   localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end

   settle_state_e state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SETTLE_IDLE;
         cnt_q   <= '0;
      end else if (start_i) begin
         state_q <= SETTLE_RUN;
         cnt_q   <= LOAD;
      end else if (state_q == SETTLE_RUN) begin
         if (cnt_q == '0) state_q <= SETTLE_IDLE;
         else             cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign ready_o = (state_q == SETTLE_IDLE);

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);

   p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SETTLE_RUN && cnt_q != '0) |=> !ready_o);

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!ready_o && cnt_q == LOAD));
endmodule

// File: rtl/sbc_bank_array.sv
module sbc_bank_array #(
   parameter int NUM_BANKS      = 8,
   parameter int WORDS_PER_BANK = 16,
   parameter int DATA_W         = 32
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          acc_valid_i,
   input  logic                                          acc_write_i,
   input  logic [$clog2(NUM_BANKS*WORDS_PER_BANK)-1:0]   acc_addr_i,
   input  logic [DATA_W-1:0]                             acc_wdata_i,
   input  logic [NUM_BANKS-1:0]                          bank_en_i,
   output logic                                          rvalid_o,
   output logic [DATA_W-1:0]                             rdata_o
);
   localparam int AW = $clog2(NUM_BANKS * WORDS_PER_BANK);
   localparam int OW = $clog2(WORDS_PER_BANK);
   localparam int BW = AW - OW;

   logic [BW-1:0] bank_sel;
   logic [OW-1:0] offset;
   logic [DATA_W-1:0] rd_word [NUM_BANKS];

   assign bank_sel = acc_addr_i[AW-1:OW];
   assign offset   = acc_addr_i[OW-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem_q [WORDS_PER_BANK];
      logic wr_hit;

      assign wr_hit = acc_valid_i && acc_write_i &&
                      (bank_sel == BW'(b)) && bank_en_i[b];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WORDS_PER_BANK; w++) mem_q[w] <= '0;
         end else if (wr_hit) begin
            mem_q[offset] <= acc_wdata_i;
         end
      end

      assign rd_word[b] = mem_q[offset];
   end

   logic rd_fire;
   assign rd_fire = acc_valid_i && !acc_write_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         rvalid_o <= rd_fire;
         if (rd_fire) rdata_o <= bank_en_i[bank_sel] ? rd_word[bank_sel] : '0;
      end
   end

   p_off_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !bank_en_i[bank_sel]) |=> (rdata_o == '0));

   p_rvalid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> rvalid_o);

   p_rvalid_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> !rvalid_o);
endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl #(
   parameter int NUM_BANKS      = 8,
   parameter int WORDS_PER_BANK = 16,
   parameter int DATA_W         = 32,
   parameter int SETTLE_CYCLES  = 6
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        cfg_we,
   input  logic [NUM_BANKS-1:0]                        cfg_wdata,
   output logic [NUM_BANKS-1:0]                        cfg_en,
   output logic                                        cfg_ready,
   input  logic                                        mem_valid,
   input  logic                                        mem_write,
   input  logic [$clog2(NUM_BANKS*WORDS_PER_BANK)-1:0] mem_addr,
   input  logic [DATA_W-1:0]                           mem_wdata,
   output logic                                        mem_ready,
   output logic                                        mem_rvalid,
   output logic [DATA_W-1:0]                           mem_rdata
);
   localparam logic [NUM_BANKS-1:0] ONE_HOT0 = NUM_BANKS'(1);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_nb
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (WORDS_PER_BANK < 2 || (WORDS_PER_BANK & (WORDS_PER_BANK - 1)) != 0) begin : g_bad_wpb
      $error("WORDS_PER_BANK must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic [NUM_BANKS-1:0] norm;
   logic [NUM_BANKS-1:0] en_q;
   logic                 change;
   logic                 settled;

   sbc_normalize #(.NUM_BANKS(NUM_BANKS)) u_norm (
      .raw_i  (cfg_wdata),
      .norm_o (norm)
   );

   assign change = cfg_we && (norm != en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '1;
      else if (change) en_q <= norm;
   end

   sbc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (change),
      .ready_o (settled)
   );

   assign cfg_en    = en_q;
   assign cfg_ready = settled;
   assign mem_ready = settled;

   sbc_bank_array #(
      .NUM_BANKS      (NUM_BANKS),
      .WORDS_PER_BANK (WORDS_PER_BANK),
      .DATA_W         (DATA_W)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid_i (mem_valid && settled),
      .acc_write_i (mem_write),
      .acc_addr_i  (mem_addr),
      .acc_wdata_i (mem_wdata),
      .bank_en_i   (en_q),
      .rvalid_o    (mem_rvalid),
      .rdata_o     (mem_rdata)
   );

   p_bank0_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en[0]);

   p_contiguous_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en & (cfg_en + ONE_HOT0)) == '0);

   p_change_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && norm != cfg_en) |=> !cfg_ready);

   p_same_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && norm == cfg_en && cfg_ready) |=> (cfg_ready && $stable(cfg_en)));

   p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ready |=> !mem_rvalid);
endmodule

// File: tb/tb_sram_bank_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bank_ctrl;
   localparam int NB  = 8;
   localparam int WPB = 16;
   localparam int DW  = 32;
   localparam int SC  = 6;
   localparam int AW  = $clog2(NB*WPB);

   logic clk = 0;
   logic rst_n = 0;
   logic cfg_we = 0;
   logic [NB-1:0] cfg_wdata = '0;
   logic [NB-1:0] cfg_en;
   logic cfg_ready;
   logic mem_valid = 0, mem_write = 0;
   logic [AW-1:0] mem_addr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic mem_ready, mem_rvalid;
   logic [DW-1:0] mem_rdata;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   sram_bank_ctrl #(.NUM_BANKS(NB), .WORDS_PER_BANK(WPB), .DATA_W(DW), .SETTLE_CYCLES(SC)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_en(cfg_en), .cfg_ready(cfg_ready), .mem_valid(mem_valid),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

   // Reference model
   logic [NB-1:0] m_en;
   bit            m_busy;
   int            m_cnt;
   logic [DW-1:0] m_mem [NB*WPB];
   bit            m_rvalid;
   logic [DW-1:0] m_rdata;

   function automatic logic [NB-1:0] fill(input logic [NB-1:0] w);
      logic [NB-1:0] r;
      bit seen;
      seen = 0;
      for (int i = NB-1; i >= 0; i--) begin
         if (w[i]) seen = 1;
         r[i] = seen;
      end
      r[0] = 1'b1;
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '1; m_busy = 0; m_cnt = 0; m_rvalid = 0; m_rdata = '0;
         for (int i = 0; i < NB*WPB; i++) m_mem[i] = '0;
      end else begin
         automatic bit acc = mem_valid && !m_busy;
         automatic int bk = int'(mem_addr) / WPB;
         m_rvalid = acc && !mem_write;
         if (acc && mem_write && m_en[bk]) m_mem[mem_addr] = mem_wdata;
         if (acc && !mem_write) m_rdata = m_en[bk] ? m_mem[mem_addr] : '0;
         if (m_busy) begin
            if (m_cnt == 0) m_busy = 0; else m_cnt--;
         end
         if (cfg_we && fill(cfg_wdata) != m_en) begin
            m_en = fill(cfg_wdata); m_busy = 1; m_cnt = SC-1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(cfg_en == m_en, "R3 cfg_en vs model", cfg_en, m_en);
         check(cfg_ready == !m_busy, "R4 cfg_ready vs model", cfg_ready, !m_busy);
         check(mem_ready == !m_busy, "R6 mem_ready vs model", mem_ready, !m_busy);
         check(mem_rvalid == m_rvalid, "R9 rvalid vs model", mem_rvalid, m_rvalid);
         if (m_rvalid)
            check(mem_rdata == m_rdata, "R9 rdata vs model", mem_rdata, m_rdata);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic cfg_write(input logic [NB-1:0] v);
      cfg_we = 1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic mem_op(input bit wr, input int addr, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output int waited);
      bit r;
      waited = 0;
      mem_valid = 1; mem_write = wr; mem_addr = AW'(addr); mem_wdata = d;
      forever begin
         r = mem_ready;
         @(negedge clk);
         if (r) break;
         waited++;
      end
      mem_valid = 0;
      rd = mem_rdata;
   endtask

   task automatic low_count(output int n);
      n = 0;
      while (!cfg_ready && n < 100) begin n++; @(negedge clk); end
   endtask

   initial begin
      logic [DW-1:0] rd;
      int w, n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(cfg_en == '1, "R1 reset enable", cfg_en, 8'hFF);
      check(cfg_ready && mem_ready, "R1 reset ready", {cfg_ready, mem_ready}, 2'b11);

      // R9 write/read in enabled banks
      mem_op(1, 5*WPB+3, 32'hA5A5_0005, rd, w);
      mem_op(1, 1*WPB+2, 32'h1111_0001, rd, w);
      mem_op(0, 5*WPB+3, '0, rd, w);
      check(rd == 32'hA5A5_0005, "R9 readback", rd, 32'hA5A5_0005);

      // R3 fill of a hole pattern, R4 settle window length
      cfg_write(8'b0001_0111);
      check(cfg_en == 8'b0001_1111, "R3 fill 00010111", cfg_en, 8'h1F);
      low_count(n);
      check(n == SC, "R4 settle length", n, SC);

      // R7 disabled bank reads zero
      mem_op(0, 5*WPB+3, '0, rd, w);
      check(rd == '0, "R7 disabled read zero", rd, 0);

      // R8 write to disabled bank discarded
      mem_op(1, 5*WPB+3, 32'hDEAD_BEEF, rd, w);
      cfg_write(8'hFF);
      low_count(n);
      mem_op(0, 5*WPB+3, '0, rd, w);
      check(rd == 32'hA5A5_0005, "R8 discarded write", rd, 32'hA5A5_0005);

      // R2 bank 0 cannot be cleared
      cfg_write(8'h00);
      check(cfg_en == 8'h01, "R2 bank0 forced", cfg_en, 1);
      // R6 a read held during settle completes afterwards
      mem_op(0, 0*WPB+0, '0, rd, w);
      check(w > 0, "R6 read stalled", w, SC);
      check(rd == '0, "R6 stalled read data", rd, 0);

      // R5 same value leaves ready alone
      cfg_write(8'h01);
      check(cfg_ready == 1'b1, "R5 no settle on equal", cfg_ready, 1);
      cfg_write(8'h00);
      check(cfg_ready == 1'b1, "R5 no settle on equal normalised", cfg_ready, 1);

      // R10 restart during settle
      cfg_write(8'b0000_0010);
      repeat (3) @(negedge clk);
      cfg_write(8'b1000_0000);
      low_count(n);
      check(n == SC, "R10 restart window", n, SC);
      check(cfg_en == 8'hFF, "R3 fill top bit", cfg_en, 8'hFF);

      // R6 write held during settle lands after
      cfg_write(8'b0000_0011);
      mem_op(1, 1*WPB+4, 32'h0BAD_F00D, rd, w);
      check(w > 0, "R6 write stalled", w, SC);
      mem_op(0, 1*WPB+4, '0, rd, w);
      check(rd == 32'h0BAD_F00D, "R6 stalled write data", rd, 32'h0BAD_F00D);
      mem_op(0, 1*WPB+2, '0, rd, w);
      check(rd == 32'h1111_0001, "R9 older word kept", rd, 32'h1111_0001);

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule